// File: doc/BRIEF.md
# Table-Routed Packet Switch Element

This block is a four-port store-and-forward switching element for token packets. Each packet names a destination processing element in its upper bits. A packet can enter on any of the input streams, and several inputs may present packets in the same cycle. Each input has a small buffer. The packet at the head of each buffer looks up its destination in a routing table held inside the switch. The table entry is a mask of every output port that brings the packet nearer its target.

The head packet leaves on the lowest-numbered port in its mask that can take a packet in that cycle. If no port in the mask is free, the packet stays in its input buffer and tries again in the next cycle. When two or more inputs want the same output in one cycle, a round-robin arbiter for that output decides between them. A destination whose table entry is empty cannot be routed. Such a packet is discarded and counted. Software or a setup sequencer fills the table through a simple write port before traffic starts. The table can also be rewritten while the switch runs.

Top module: `route_switch`

## Requirements
- R1: After reset, every input ready is high, every output valid is low, the drop counter reads zero and every table entry is zero.
- R2: A packet is `{dest, data}`, with the destination in the upper DEST_W bits. It leaves unchanged on an output whose bit is set in the table entry for its destination.
- R3: When several ports in the mask are free, the packet takes the lowest-numbered one. A port that holds an unaccepted packet is not free, and the packet then goes to the next free candidate.
- R4: A packet with no free candidate port waits in its input buffer. No packet is lost or duplicated, and packets from one input to one output keep their order.
- R5: Each input buffer holds DEPTH packets. Input ready is low while the buffer is full.
- R6: Inputs that compete for one output are served in round-robin order. After input k wins, the search for that output starts at input k+1. At most one input wins an output per cycle, and each input wins at most one output.
- R7: A head packet whose table mask is all zero is removed without output. The drop counter then rises by the number of such packets removed in that cycle.
- R8: While an output's valid is high and its ready is low, the output valid stays high and the packet stays stable.
- R9: A packet accepted at clock edge N appears on its output after edge N+1. Four packets to four distinct ports that arrive together appear together.
- R10: A table write at one edge applies to every lookup made after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | NPORT | Per-input packet valid |
| in_ready | output | NPORT | Per-input buffer has room |
| in_pkt | input | NPORT*(DEST_W+DATA_W) | Input packets, port i in slice i |
| out_valid | output | NPORT | Per-output packet valid |
| out_ready | input | NPORT | Per-output downstream accepts |
| out_pkt | output | NPORT*(DEST_W+DATA_W) | Output packets, port o in slice o |
| tbl_we | input | 1 | Routing table write strobe |
| tbl_addr | input | DEST_W | Destination entry to write |
| tbl_mask | input | NPORT | Candidate output mask to store |
| drop_count | output | CNT_W | Count of unroutable packets discarded |

## Verification
The bench builds the switch with its defaults: four ports, sixteen destinations, four-entry buffers and a 16-bit drop counter. The shallow buffer lets one stalled output fill an input after five packets, so the full/ready boundary is quick to reach. The four-port width keeps a two-candidate mask and a fully crossed all-input pattern small enough to predict by hand. Sixteen destinations leave entries that are never written, so the zero-mask discard path can be tested next to a live rewrite of one entry.

// File: rtl/rsw_pkg.sv
package rsw_pkg;

  // Index of the least significant set bit, or -1 when none is set.
  function automatic int lowest_index(input logic [63:0] v);
    int idx;
    idx = -1;
    for (int k = 63; k >= 0; k--) begin
      if (v[k]) idx = k;
    end
    return idx;
  endfunction

  // Number of set bits.
  function automatic int bit_total(input logic [63:0] v);
    int n;
    n = 0;
    for (int k = 0; k < 64; k++) begin
      if (v[k]) n++;
    end
    return n;
  endfunction

  // Modular successor used by pointers and the round-robin search.
  function automatic int wrap_next(input int idx, input int n);
    return (idx + 1 >= n) ? 0 : idx + 1;
  endfunction

endpackage

// File: rtl/rsw_fifo.sv
module rsw_fifo
  import rsw_pkg::*;
#(
  parameter int W     = 20,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push,
  input  logic [W-1:0] din,
  input  logic         pop,
  output logic [W-1:0] dout,
  output logic         empty,
  output logic         full
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          do_push, do_pop;

  assign empty   = (cnt == '0);
  assign full    = (cnt == CW'(DEPTH));
  assign do_push = push && !full;
  assign do_pop  = pop && !empty;
  assign dout    = mem[rp];

  always_ff @(posedge clk) begin
    if (do_push) mem[wp] <= din;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp  <= '0;
      rp  <= '0;
      cnt <= '0;
    end else begin
      if (do_push) wp <= AW'(wrap_next(int'(wp), DEPTH));
      if (do_pop)  rp <= AW'(wrap_next(int'(rp), DEPTH));
      case ({do_push, do_pop})
        2'b10:   cnt <= cnt + 1'b1;
        2'b01:   cnt <= cnt - 1'b1;
        default: cnt <= cnt;
      endcase
    end
  end
endmodule

// File: rtl/rsw_rr_arb.sv
module rsw_rr_arb
  import rsw_pkg::*;
#(
  parameter int N = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] req,
  output logic [N-1:0] grant
);
  localparam int IW = (N > 1) ? $clog2(N) : 1;

  logic [IW-1:0] start_q;
  int            win;

  // Search starts at start_q and wraps; first requester found wins.
  always_comb begin
    grant = '0;
    win   = 0;
    for (int k = N - 1; k >= 0; k--) begin
      int idx;
      idx = (int'(start_q) + k) % N;
      if (req[idx]) win = idx;
    end
    if (|req) grant[win] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      start_q <= '0;
    else if (|req)   start_q <= IW'(wrap_next(win, N));
  end
endmodule

// File: rtl/rsw_route_table.sv
module rsw_route_table #(
  parameter int NPORT  = 4,
  parameter int DEST_W = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    we,
  input  logic [DEST_W-1:0]       waddr,
  input  logic [NPORT-1:0]        wmask,
  input  logic [NPORT*DEST_W-1:0] raddr,
  output logic [NPORT*NPORT-1:0]  rmask
);
  localparam int NDEST = 1 << DEST_W;

  logic [NPORT-1:0] entry [NDEST];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int d = 0; d < NDEST; d++) entry[d] <= '0;
    end else if (we) begin
      entry[waddr] <= wmask;
    end
  end

  for (genvar p = 0; p < NPORT; p++) begin : g_rd
    assign rmask[p*NPORT +: NPORT] = entry[raddr[p*DEST_W +: DEST_W]];
  end
endmodule

// File: rtl/route_switch.sv
module route_switch
  import rsw_pkg::*;
#(
  parameter int NPORT  = 4,
  parameter int DEST_W = 4,
  parameter int DATA_W = 16,
  parameter int DEPTH  = 4,
  parameter int CNT_W  = 16
) (
  input  logic                                clk,
  input  logic                                rst_n,
  input  logic [NPORT-1:0]                    in_valid,
  output logic [NPORT-1:0]                    in_ready,
  input  logic [NPORT*(DEST_W+DATA_W)-1:0]    in_pkt,
  output logic [NPORT-1:0]                    out_valid,
  input  logic [NPORT-1:0]                    out_ready,
  output logic [NPORT*(DEST_W+DATA_W)-1:0]    out_pkt,
  input  logic                                tbl_we,
  input  logic [DEST_W-1:0]                   tbl_addr,
  input  logic [NPORT-1:0]                    tbl_mask,
  output logic [CNT_W-1:0]                    drop_count
);
  localparam int PKT_W = DEST_W + DATA_W;

  // Named internal events, also observed by the bound checker.
  logic [PKT_W-1:0]         head_pkt [NPORT];
  logic [NPORT-1:0]         head_vld;
  logic [NPORT-1:0]         buf_empty;
  logic [NPORT-1:0]         buf_full;
  logic [NPORT-1:0]         drop_vec;
  logic [NPORT-1:0]         in_grant;
  logic [NPORT-1:0]         pop_vec;
  logic [NPORT-1:0]         port_free;
  logic [NPORT*DEST_W-1:0]  lookup_dest;
  logic [NPORT*NPORT-1:0]   lookup_mask;
  logic [NPORT-1:0]         pick  [NPORT];
  logic [NPORT-1:0]         req_m [NPORT];
  logic [NPORT-1:0]         gnt_m [NPORT];
  logic [NPORT*NPORT-1:0]   grant_flat;
  logic [PKT_W-1:0]         win_pkt [NPORT];
  logic [PKT_W-1:0]         out_r   [NPORT];
  logic [NPORT-1:0]         out_v;

  // Routing table
  rsw_route_table #(
    .NPORT  (NPORT),
    .DEST_W (DEST_W)
  ) u_table (
    .clk   (clk),
    .rst_n (rst_n),
    .we    (tbl_we),
    .waddr (tbl_addr),
    .wmask (tbl_mask),
    .raddr (lookup_dest),
    .rmask (lookup_mask)
  );

  // Input side: buffer, lookup, candidate choice
  for (genvar i = 0; i < NPORT; i++) begin : g_in
    logic [NPORT-1:0] mask_i;

    rsw_fifo #(
      .W     (PKT_W),
      .DEPTH (DEPTH)
    ) u_buf (
      .clk   (clk),
      .rst_n (rst_n),
      .push  (in_valid[i] & in_ready[i]),
      .din   (in_pkt[i*PKT_W +: PKT_W]),
      .pop   (pop_vec[i]),
      .dout  (head_pkt[i]),
      .empty (buf_empty[i]),
      .full  (buf_full[i])
    );

    assign head_vld[i] = !buf_empty[i];
    assign in_ready[i] = !buf_full[i];
    assign lookup_dest[i*DEST_W +: DEST_W] = head_pkt[i][PKT_W-1 -: DEST_W];
    assign mask_i      = lookup_mask[i*NPORT +: NPORT];
    assign drop_vec[i] = head_vld[i] && (mask_i == '0);

    always_comb begin
      int li;
      li      = lowest_index(64'(mask_i & port_free));
      pick[i] = '0;
      if (head_vld[i] && li >= 0) pick[i] = NPORT'(1) << li;
    end
  end

  // Transpose picks into per-output request vectors; gather input grants.
  always_comb begin
    for (int o = 0; o < NPORT; o++) begin
      for (int i = 0; i < NPORT; i++) begin
        req_m[o][i] = pick[i][o];
      end
    end
  end

  always_comb begin
    for (int i = 0; i < NPORT; i++) begin
      in_grant[i] = 1'b0;
      for (int o = 0; o < NPORT; o++) begin
        in_grant[i] = in_grant[i] | gnt_m[o][i];
      end
    end
  end

  assign pop_vec = in_grant | drop_vec;

  // Output side: arbiter and output register per port
  for (genvar o = 0; o < NPORT; o++) begin : g_out
    rsw_rr_arb #(
      .N (NPORT)
    ) u_arb (
      .clk   (clk),
      .rst_n (rst_n),
      .req   (req_m[o]),
      .grant (gnt_m[o])
    );

    assign port_free[o] = !out_v[o] || out_ready[o];
    assign grant_flat[o*NPORT +: NPORT] = gnt_m[o];

    always_comb begin
      win_pkt[o] = '0;
      for (int i = 0; i < NPORT; i++) begin
        if (gnt_m[o][i]) win_pkt[o] = head_pkt[i];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        out_v[o] <= 1'b0;
        out_r[o] <= '0;
      end else if (|gnt_m[o]) begin
        out_v[o] <= 1'b1;
        out_r[o] <= win_pkt[o];
      end else if (out_ready[o]) begin
        out_v[o] <= 1'b0;
      end
    end

    assign out_valid[o]                = out_v[o];
    assign out_pkt[o*PKT_W +: PKT_W]   = out_r[o];
  end

  // Discard tally
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drop_count <= '0;
    else        drop_count <= drop_count + CNT_W'(bit_total(64'(drop_vec)));
  end
endmodule

// File: rtl/route_switch_chk.sv
module route_switch_chk #(
  parameter int NPORT  = 4,
  parameter int DEST_W = 4,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 16
) (
  input logic                               clk,
  input logic                               rst_n,
  input logic [NPORT-1:0]                   in_ready,
  input logic [NPORT-1:0]                   buf_full,
  input logic [NPORT-1:0]                   out_valid,
  input logic [NPORT-1:0]                   out_ready,
  input logic [NPORT*(DEST_W+DATA_W)-1:0]   out_pkt,
  input logic [CNT_W-1:0]                   drop_count,
  input logic [NPORT-1:0]                   drop_vec,
  input logic [NPORT*NPORT-1:0]             grant_flat,
  input logic [NPORT-1:0]                   port_free
);
  localparam int PKT_W = DEST_W + DATA_W;

  logic [NPORT-1:0] col [NPORT];

  always_comb begin
    for (int i = 0; i < NPORT; i++) begin
      for (int o = 0; o < NPORT; o++) begin
        col[i][o] = grant_flat[o*NPORT + i];
      end
    end
  end

  for (genvar o = 0; o < NPORT; o++) begin : g_o
    a_r8_hold_stable: assert property (@(posedge clk) disable iff (!rst_n)
      out_valid[o] && !out_ready[o] |=> out_valid[o] && $stable(out_pkt[o*PKT_W +: PKT_W]));

    a_r6_one_winner: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(grant_flat[o*NPORT +: NPORT]));

    a_r2_grant_needs_free: assert property (@(posedge clk) disable iff (!rst_n)
      |grant_flat[o*NPORT +: NPORT] |-> port_free[o]);

    a_r9_load_follows_grant: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(out_valid[o]) |-> $past(|grant_flat[o*NPORT +: NPORT]));
  end

  for (genvar i = 0; i < NPORT; i++) begin : g_i
    a_r5_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      buf_full[i] |-> !in_ready[i]);

    a_r6_one_port_per_input: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(col[i]));

    a_r7_drop_not_granted: assert property (@(posedge clk) disable iff (!rst_n)
      drop_vec[i] |-> !(|col[i]));
  end

  a_r7_drop_tally: assert property (@(posedge clk) disable iff (!rst_n)
    |drop_vec |=> drop_count == $past(drop_count) + CNT_W'($countones($past(drop_vec))));

  a_r7_tally_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !(|drop_vec) |=> $stable(drop_count));
endmodule

bind route_switch route_switch_chk #(
  .NPORT  (NPORT),
  .DEST_W (DEST_W),
  .DATA_W (DATA_W),
  .CNT_W  (CNT_W)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .in_ready   (in_ready),
  .buf_full   (buf_full),
  .out_valid  (out_valid),
  .out_ready  (out_ready),
  .out_pkt    (out_pkt),
  .drop_count (drop_count),
  .drop_vec   (drop_vec),
  .grant_flat (grant_flat),
  .port_free  (port_free)
);

// File: tb/route_switch_bench.sv
module route_switch_bench;
  localparam int NPORT  = 4;
  localparam int DEST_W = 4;
  localparam int DATA_W = 16;
  localparam int DEPTH  = 4;
  localparam int CNT_W  = 16;
  localparam int PKT_W  = DEST_W + DATA_W;

  logic                     clk = 1'b0;
  logic                     rst_n = 1'b0;
  logic [NPORT-1:0]         in_valid = '0;
  logic [NPORT-1:0]         in_ready;
  logic [NPORT*PKT_W-1:0]   in_pkt = '0;
  logic [NPORT-1:0]         out_valid;
  logic [NPORT-1:0]         out_ready = '1;
  logic [NPORT*PKT_W-1:0]   out_pkt;
  logic                     tbl_we = 1'b0;
  logic [DEST_W-1:0]        tbl_addr = '0;
  logic [NPORT-1:0]         tbl_mask = '0;
  logic [CNT_W-1:0]         drop_count;

  int n_chk = 0;
  int n_err = 0;

  logic [PKT_W-1:0] exp_q [NPORT][$];
  string            tag_q [NPORT][$];

  always #10 clk = ~clk;  // 50 MHz

  route_switch #(
    .NPORT(NPORT), .DEST_W(DEST_W), .DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)
  ) u_route_switch (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_pkt(in_pkt),
    .out_valid(out_valid), .out_ready(out_ready), .out_pkt(out_pkt),
    .tbl_we(tbl_we), .tbl_addr(tbl_addr), .tbl_mask(tbl_mask),
    .drop_count(drop_count)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int k = 0; k < n; k++) begin
      @(negedge clk); #1;
    end
  endtask

  task automatic expect_pkt(input int port, input logic [DEST_W-1:0] d,
                            input logic [DATA_W-1:0] v, input string req);
    exp_q[port].push_back({d, v});
    tag_q[port].push_back(req);
  endtask

  // Called at negedge+1; returns at negedge+1 after the accepting edge.
  task automatic send(input int i, input logic [DEST_W-1:0] d, input logic [DATA_W-1:0] v);
    in_pkt[i*PKT_W +: PKT_W] = {d, v};
    in_valid[i] = 1'b1;
    while (!in_ready[i]) begin
      @(negedge clk); #1;
    end
    @(negedge clk); #1;
    in_valid[i] = 1'b0;
  endtask

  task automatic prog(input logic [DEST_W-1:0] d, input logic [NPORT-1:0] m);
    tbl_we = 1'b1; tbl_addr = d; tbl_mask = m;
    @(negedge clk); #1;
    tbl_we = 1'b0;
  endtask

  // Scoreboard monitor: samples mid-cycle, after drivers have settled.
  initial begin
    forever begin
      @(negedge clk); #5;
      if (rst_n) begin
        for (int o = 0; o < NPORT; o++) begin
          if (out_valid[o] && out_ready[o]) begin
            logic [PKT_W-1:0] got;
            got = out_pkt[o*PKT_W +: PKT_W];
            if (exp_q[o].size() == 0) begin
              check(1'b0, "R7 unexpected output", longint'(got), 0);
            end else begin
              logic [PKT_W-1:0] want;
              string            t;
              want = exp_q[o].pop_front();
              t    = tag_q[o].pop_front();
              check(got == want, t, longint'(got), longint'(want));
            end
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end

  initial begin
    logic [PKT_W-1:0] held;
    tick(3);
    // R1: reset state
    check(in_ready == '1, "R1 ready in reset", longint'(in_ready), 15);
    check(out_valid == '0, "R1 valid in reset", longint'(out_valid), 0);
    rst_n = 1'b1;
    tick(1);
    check(drop_count == '0, "R1 drop count", longint'(drop_count), 0);
    check(in_ready == '1, "R1 ready after reset", longint'(in_ready), 15);

    prog(4'd0, 4'b0001); prog(4'd1, 4'b0010); prog(4'd3, 4'b1000);
    prog(4'd4, 4'b0010); prog(4'd5, 4'b1010); prog(4'd7, 4'b0100);
    prog(4'd10, 4'b1000); prog(4'd11, 4'b0100);
    prog(4'd12, 4'b0010); prog(4'd13, 4'b0001);

    // R2: basic routing
    expect_pkt(1, 4'd1, 16'hA101, "R2 route dest1");
    send(0, 4'd1, 16'hA101);
    expect_pkt(3, 4'd3, 16'hA303, "R2 route dest3");
    send(2, 4'd3, 16'hA303);
    expect_pkt(0, 4'd0, 16'hA000, "R2 route dest0");
    send(3, 4'd0, 16'hA000);
    tick(4);

    // R9: all inputs at once, crossed destinations
    expect_pkt(3, 4'd10, 16'hB000, "R9 in0->p3");
    expect_pkt(2, 4'd11, 16'hB001, "R9 in1->p2");
    expect_pkt(1, 4'd12, 16'hB002, "R9 in2->p1");
    expect_pkt(0, 4'd13, 16'hB003, "R9 in3->p0");
    fork
      send(0, 4'd10, 16'hB000);
      send(1, 4'd11, 16'hB001);
      send(2, 4'd12, 16'hB002);
      send(3, 4'd13, 16'hB003);
    join
    tick(1);
    check(out_valid == 4'hF, "R9 simultaneous exit", longint'(out_valid), 15);
    tick(3);

    // R6: round-robin between inputs 0 and 1 on port 2
    out_ready[2] = 1'b0;
    expect_pkt(2, 4'd7, 16'hC0A0, "R6 rr a0");
    expect_pkt(2, 4'd7, 16'hC0B0, "R6 rr b0");
    expect_pkt(2, 4'd7, 16'hC0A1, "R6 rr a1");
    expect_pkt(2, 4'd7, 16'hC0B1, "R6 rr b1");
    expect_pkt(2, 4'd7, 16'hC0A2, "R6 rr a2");
    expect_pkt(2, 4'd7, 16'hC0B2, "R6 rr b2");
    fork
      begin
        send(0, 4'd7, 16'hC0A0); send(0, 4'd7, 16'hC0A1); send(0, 4'd7, 16'hC0A2);
      end
      begin
        send(1, 4'd7, 16'hC0B0); send(1, 4'd7, 16'hC0B1); send(1, 4'd7, 16'hC0B2);
      end
    join
    tick(2);
    out_ready[2] = 1'b1;
    tick(8);

    // R3: lowest free candidate, busy port skipped
    out_ready[1] = 1'b0;
    expect_pkt(1, 4'd4, 16'hD100, "R3 blocker on p1");
    send(1, 4'd4, 16'hD100);
    tick(2);
    expect_pkt(3, 4'd5, 16'hD305, "R3 busy p1 -> p3");
    send(2, 4'd5, 16'hD305);
    tick(3);
    out_ready[1] = 1'b1;
    tick(2);
    expect_pkt(1, 4'd5, 16'hD105, "R3 both free -> p1");
    send(2, 4'd5, 16'hD105);
    tick(4);

    // R5 / R8 / R4: stall port 0 and fill input 0
    out_ready[0] = 1'b0;
    for (int k = 0; k < 5; k++) begin
      expect_pkt(0, 4'd0, 16'hE000 + 16'(k), "R4 order after stall");
      send(0, 4'd0, 16'hE000 + 16'(k));
    end
    check(in_ready[0] == 1'b0, "R5 full drops ready", longint'(in_ready[0]), 0);
    held = out_pkt[0 +: PKT_W];
    tick(3);
    check(out_valid[0] == 1'b1, "R8 valid held", longint'(out_valid[0]), 1);
    check(out_pkt[0 +: PKT_W] == {4'd0, 16'hE000}, "R8 packet held",
          longint'(out_pkt[0 +: PKT_W]), longint'({4'd0, 16'hE000}));
    check(held == out_pkt[0 +: PKT_W], "R8 packet stable", longint'(held),
          longint'(out_pkt[0 +: PKT_W]));
    check(in_ready[0] == 1'b0, "R5 still full", longint'(in_ready[0]), 0);
    out_ready[0] = 1'b1;
    tick(2);
    check(in_ready[0] == 1'b1, "R5 ready returns", longint'(in_ready[0]), 1);
    tick(6);

    // R7: zero-mask discard
    send(3, 4'd9, 16'hF009);
    tick(2);
    check(drop_count == 16'd1, "R7 single drop", longint'(drop_count), 1);
    fork
      send(2, 4'd9, 16'hF109);
      send(3, 4'd9, 16'hF209);
    join
    tick(2);
    check(drop_count == 16'd3, "R7 double drop", longint'(drop_count), 3);

    // R10: live table rewrite
    prog(4'd6, 4'b0001);
    expect_pkt(0, 4'd6, 16'h6000, "R10 first mapping");
    send(1, 4'd6, 16'h6000);
    tick(3);
    prog(4'd6, 4'b0100);
    expect_pkt(2, 4'd6, 16'h6002, "R10 rewritten mapping");
    send(1, 4'd6, 16'h6002);
    tick(10);

    for (int o = 0; o < NPORT; o++) begin
      check(exp_q[o].size() == 0, "R4 nothing lost", longint'(exp_q[o].size()), 0);
    end
    check(drop_count == 16'd3, "R7 count unchanged by routed traffic",
          longint'(drop_count), 3);

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule